// File: doc/BRIEF.md
# DMA Page Translation Unit

This block maps the addresses that a device uses for DMA into physical page addresses through a table of 64-bit translation entries. The table is held in on-chip RAM. Each entry holds a physical page address in its upper bits and an access code in its two lowest bits. A lookup takes an I/O address together with a valid strobe. One cycle later the block returns four values: the page-aligned I/O address, the translated page address, the mask of in-page offset bits and the access code.

Software controls the translation window through a small configuration interface. An enable pulse loads the page shift, the number of live entries and the base of the window. A disable pulse tears the window down again. The entries themselves are written and read through a raw table port, addressed by entry index.

An address that falls outside the window never produces an error signal. Instead it returns a fault: the access code is zero, both addresses are zero and the mask is all ones. After reset, and on every accepted enable, the whole table is swept to zero. Until software writes an entry, every page therefore faults.

Top module: `tce_xlate`

## Requirements
- R1: `rsp_valid` is high exactly in the cycle after each cycle in which `req_valid` is high, and is low otherwise.
- R2: The entry index is `(req_addr - base) >> shift`. An address is inside the window only when `req_addr >= base` and the index is less than the live entry count.
- R3: A lookup outside the window returns `rsp_perm`=0, `rsp_paddr`=0, `rsp_iova`=0 and `rsp_mask` all ones.
- R4: For a lookup inside the window, the page mask is all ones with its low `shift` bits cleared. `rsp_paddr` is the entry ANDed with the page mask. `rsp_iova` is `(req_addr - base)` ANDed with the page mask. `rsp_mask` is the inverted page mask, which equals 2^shift - 1.
- R5: For a lookup inside the window, `rsp_perm` is bits [1:0] of the entry. The codes are: 0 no access, 1 read only, 2 write only, 3 read and write.
- R6: Reset leaves the unit disabled, with entry count 0, shift 12 and base 0. After reset is released, all DEPTH entries are cleared over DEPTH cycles. While this clearing runs, lookups fault and table writes are ignored.
- R7: An enable pulse given while the unit is disabled does three things. It loads shift, base and count, with the count clamped to DEPTH. It clears the table over DEPTH cycles. A count of 0 leaves the unit disabled.
- R8: An enable pulse given while the unit is enabled (count non-zero) is ignored. The configuration and the table contents are unchanged.
- R9: A disable pulse sets the count, shift and base to zero, so every later lookup faults. If enable and disable arrive in the same cycle, disable wins.
- R10: A table write whose index is not less than the live count is ignored. A table read returns the raw entry one cycle later, with `tbl_rvalid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Enable pulse; loads the window configuration |
| cfg_disable | input | 1 | Disable pulse; clears the window configuration |
| cfg_shift | input | SW | Page shift loaded on enable (must be below AW) |
| cfg_count | input | CW | Requested live entry count |
| cfg_base | input | AW | Window base address |
| tbl_we | input | 1 | Table write strobe |
| tbl_re | input | 1 | Table read strobe |
| tbl_idx | input | IW | Table entry index |
| tbl_wdata | input | EW | Entry value to write |
| tbl_rvalid | output | 1 | Read data valid |
| tbl_rdata | output | EW | Entry value read |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | AW | I/O address to translate |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_iova | output | AW | Page-aligned I/O address relative to base |
| rsp_paddr | output | EW | Translated page address |
| rsp_mask | output | AW | In-page offset mask |
| rsp_perm | output | 2 | Access code |

## Verification
The bench builds the unit with DEPTH=16 and AW=48. A table of that depth keeps every clearing sweep to 16 cycles, which leaves room to probe lookups and writes while a sweep is still running. It also means that a requested count of 20 exercises the clamp. The bench runs page shifts of 12, 0 and 16. Shift 0 gives a zero offset mask, and shift 16 moves the mask past the 4 KiB default, so both ends of the mask arithmetic are covered.

// File: rtl/tce_xlate.sv
module tce_xlate #(
  parameter int DEPTH     = 64,
  parameter int AW        = 48,
  parameter int EW        = 64,
  parameter int SW        = 6,
  parameter int CW        = 32,
  parameter int DEF_SHIFT = 12,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int NW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_enable,
  input  logic          cfg_disable,
  input  logic [SW-1:0] cfg_shift,
  input  logic [CW-1:0] cfg_count,
  input  logic [AW-1:0] cfg_base,
  input  logic          tbl_we,
  input  logic          tbl_re,
  input  logic [IW-1:0] tbl_idx,
  input  logic [EW-1:0] tbl_wdata,
  output logic          tbl_rvalid,
  output logic [EW-1:0] tbl_rdata,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  output logic          rsp_valid,
  output logic [AW-1:0] rsp_iova,
  output logic [EW-1:0] rsp_paddr,
  output logic [AW-1:0] rsp_mask,
  output logic [1:0]    rsp_perm
);

  logic [NW-1:0] count_q;
  logic [SW-1:0] shift_q;
  logic [AW-1:0] base_q;
  logic          clr_q;
  logic [IW-1:0] clr_idx;

  logic [EW-1:0] mem [DEPTH];
  logic [EW-1:0] ram_q;
  logic [EW-1:0] pm_e_q;
  logic [AW-1:0] pm_a_q, iova_q;
  logic          hit_q;

  wire enabled = count_q != '0;
  wire en_take = cfg_enable && !cfg_disable && !enabled;
  wire [NW-1:0] count_clamp = (cfg_count > CW'(DEPTH)) ? NW'(DEPTH) : cfg_count[NW-1:0];

  wire [AW-1:0] rel  = req_addr - base_q;
  wire [AW-1:0] slot = rel >> shift_q;
  wire          hit  = !clr_q && (req_addr >= base_q) && (slot < AW'(count_q));
  wire [IW-1:0] lk_idx = slot[IW-1:0];
  wire [EW-1:0] pm_e = ~((EW'(1) << shift_q) - EW'(1));
  wire [AW-1:0] pm_a = ~((AW'(1) << shift_q) - AW'(1));
  wire          tw_ok = tbl_we && !clr_q && (32'(tbl_idx) < 32'(count_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      shift_q <= SW'(DEF_SHIFT);
      base_q  <= '0;
    end else if (cfg_disable) begin
      count_q <= '0;
      shift_q <= '0;
      base_q  <= '0;
    end else if (en_take) begin
      count_q <= count_clamp;
      shift_q <= cfg_shift;
      base_q  <= cfg_base;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clr_q   <= 1'b1;
      clr_idx <= '0;
    end else if (en_take) begin
      clr_q   <= 1'b1;
      clr_idx <= '0;
    end else if (clr_q) begin
      clr_idx <= clr_idx + 1'b1;
      if (clr_idx == IW'(DEPTH - 1)) clr_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (clr_q) mem[clr_idx] <= '0;
    else if (tw_ok) mem[tbl_idx] <= tbl_wdata;
    ram_q     <= mem[lk_idx];
    tbl_rdata <= mem[tbl_idx];
    pm_e_q    <= pm_e;
    pm_a_q    <= pm_a;
    iova_q    <= rel & pm_a;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      tbl_rvalid <= 1'b0;
      hit_q      <= 1'b0;
    end else begin
      rsp_valid  <= req_valid;
      tbl_rvalid <= tbl_re;
      hit_q      <= hit;
    end
  end

  assign rsp_iova  = hit_q ? iova_q : '0;
  assign rsp_paddr = hit_q ? (ram_q & pm_e_q) : '0;
  assign rsp_mask  = hit_q ? ~pm_a_q : '1;
  assign rsp_perm  = hit_q ? ram_q[1:0] : 2'b00;

endmodule

// File: rtl/tce_xlate_chk.sv
module tce_xlate_chk #(
  parameter int DEPTH = 64,
  parameter int AW    = 48,
  parameter int EW    = 64,
  parameter int SW    = 6,
  localparam int NW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          cfg_enable,
  input logic          cfg_disable,
  input logic          rsp_valid,
  input logic [AW-1:0] rsp_iova,
  input logic [EW-1:0] rsp_paddr,
  input logic [AW-1:0] rsp_mask,
  input logic [1:0]    rsp_perm,
  input logic [NW-1:0] count_q,
  input logic [SW-1:0] shift_q,
  input logic [AW-1:0] base_q
);

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n) req_valid |=> rsp_valid); // R1
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n) !req_valid |=> !rsp_valid); // R1
  AST_FAULT_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_mask == '1) |-> (rsp_perm == 2'b00 && rsp_paddr == '0 && rsp_iova == '0)); // R3
  AST_PADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((rsp_paddr[AW-1:0] & rsp_mask) == '0)); // R4
  AST_IOVA_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((rsp_iova & rsp_mask) == '0)); // R4
  AST_COUNT_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n) 32'(count_q) <= DEPTH); // R7
  AST_REENABLE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_enable && !cfg_disable && count_q != '0) |=> ($stable(count_q) && $stable(shift_q) && $stable(base_q))); // R8
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_disable |=> (count_q == '0 && shift_q == '0 && base_q == '0)); // R9
  AST_DISABLED_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(count_q) == '0) |-> rsp_mask == '1); // R9

endmodule

bind tce_xlate tce_xlate_chk #(.DEPTH(DEPTH), .AW(AW), .EW(EW), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .cfg_enable(cfg_enable),
  .cfg_disable(cfg_disable), .rsp_valid(rsp_valid), .rsp_iova(rsp_iova),
  .rsp_paddr(rsp_paddr), .rsp_mask(rsp_mask), .rsp_perm(rsp_perm),
  .count_q(count_q), .shift_q(shift_q), .base_q(base_q)
);

// File: tb/tb_tce_xlate.sv
module tb_tce_xlate;
  localparam int DEPTH = 16;
  localparam int AW = 48;
  localparam int EW = 64;
  localparam int SW = 6;
  localparam int CW = 32;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_enable = 1'b0, cfg_disable = 1'b0;
  logic [SW-1:0] cfg_shift = '0;
  logic [CW-1:0] cfg_count = '0;
  logic [AW-1:0] cfg_base = '0;
  logic tbl_we = 1'b0, tbl_re = 1'b0;
  logic [IW-1:0] tbl_idx = '0;
  logic [EW-1:0] tbl_wdata = '0;
  logic tbl_rvalid;
  logic [EW-1:0] tbl_rdata;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic rsp_valid;
  logic [AW-1:0] rsp_iova, rsp_mask;
  logic [EW-1:0] rsp_paddr;
  logic [1:0] rsp_perm;

  always #5 clk = ~clk;

  tce_xlate #(.DEPTH(DEPTH), .AW(AW), .EW(EW), .SW(SW), .CW(CW)) dut (.*);

  int checks = 0;
  int errors = 0;

  logic [AW-1:0] q_iova[$];
  logic [EW-1:0] q_paddr[$];
  logic [AW-1:0] q_mask[$];
  logic [1:0]    q_perm[$];
  string         q_tag[$];

  logic [EW-1:0] m_tbl [DEPTH];
  int m_cnt = 0;
  int m_shift = 12;
  logic [AW-1:0] m_base = '0;
  bit m_busy = 1'b1;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (q_tag.size() == 0) begin
        check("R1 unexpected response", 64'd1, 64'd0);
      end else begin
        string t;
        t = q_tag.pop_front();
        check({t, " iova"},  64'(rsp_iova),  64'(q_iova.pop_front()));
        check({t, " paddr"}, rsp_paddr,      q_paddr.pop_front());
        check({t, " mask"},  64'(rsp_mask),  64'(q_mask.pop_front()));
        check({t, " perm"},  64'(rsp_perm),  64'(q_perm.pop_front()));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check("R1 watchdog expired", 64'd1, 64'd0);
    finish_run();
  end

  task automatic lookup(input logic [AW-1:0] a, input string tag);
    logic [AW-1:0] rel, slot;
    logic [63:0] pm, e;
    rel  = a - m_base;
    slot = rel >> m_shift;
    pm   = ~((64'd1 << m_shift) - 64'd1);
    if (m_busy || a < m_base || slot >= AW'(m_cnt)) begin
      q_iova.push_back('0); q_paddr.push_back('0);
      q_mask.push_back('1); q_perm.push_back(2'b00);
    end else begin
      e = m_tbl[slot[IW-1:0]];
      q_iova.push_back(rel & pm[AW-1:0]); q_paddr.push_back(e & pm);
      q_mask.push_back(~pm[AW-1:0]); q_perm.push_back(e[1:0]);
    end
    q_tag.push_back(tag);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic tbl_write(input int idx, input logic [EW-1:0] d);
    if (!m_busy && idx < m_cnt) m_tbl[idx] = d;
    tbl_we = 1'b1; tbl_idx = IW'(idx); tbl_wdata = d;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic tbl_read(input int idx, input logic [EW-1:0] exp, input string tag);
    tbl_re = 1'b1; tbl_idx = IW'(idx);
    @(negedge clk);
    tbl_re = 1'b0;
    check({tag, " rvalid"}, 64'(tbl_rvalid), 64'd1);
    check({tag, " rdata"}, tbl_rdata, exp);
  endtask

  task automatic enable(input int sh, input int cnt, input logic [AW-1:0] b);
    if (m_cnt == 0) begin
      m_cnt = (cnt > DEPTH) ? DEPTH : cnt;
      m_shift = sh; m_base = b; m_busy = 1'b1;
      for (int i = 0; i < DEPTH; i++) m_tbl[i] = '0;
    end
    cfg_enable = 1'b1; cfg_shift = SW'(sh); cfg_count = CW'(cnt); cfg_base = b;
    @(negedge clk);
    cfg_enable = 1'b0;
  endtask

  task automatic disable_win(input bit with_enable);
    m_cnt = 0; m_shift = 0; m_base = '0;
    cfg_disable = 1'b1; cfg_enable = with_enable;
    @(negedge clk);
    cfg_disable = 1'b0; cfg_enable = 1'b0;
  endtask

  task automatic settle();
    repeat (DEPTH + 2) @(negedge clk);
    m_busy = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) m_tbl[i] = '0;
    repeat (3) @(negedge clk);
    check("R6 reset rsp_valid", 64'(rsp_valid), 64'd0);
    check("R6 reset tbl_rvalid", 64'(tbl_rvalid), 64'd0);
    rst_n = 1'b1;
    lookup(48'h0, "R6 fault after reset");
    settle();
    lookup(48'h1234, "R6 disabled after reset");

    enable(12, 8, 48'h10000);
    lookup(48'h10000, "R7 fault during sweep");
    settle();
    tbl_write(0, 64'h0000_0012_3456_7003);
    tbl_write(1, 64'h0000_00AB_CDEF_F0F1);
    tbl_write(2, 64'h0000_0000_5555_5AA2);
    tbl_write(3, 64'h8000_0000_0000_1000);
    tbl_write(9, 64'hDEAD_BEEF_0000_0003);
    lookup(48'h10ABC, "R4/R5 idx0 rw");
    lookup(48'h11FFF, "R4/R5 idx1 ro");
    lookup(48'h12800, "R4/R5 idx2 wo");
    lookup(48'h13004, "R5 idx3 no access");
    lookup(48'h17FFF, "R2 last live entry");
    lookup(48'h18000, "R3 index equals count");
    lookup(48'h0FFFF, "R2 below base");
    lookup(48'h10001, "R1 back to back");

    enable(16, 4, 48'h0);
    lookup(48'h11FFF, "R8 reenable ignored");
    tbl_read(1, 64'h0000_00AB_CDEF_F0F1, "R8 table kept");
    tbl_read(9, 64'h0, "R10 out of count write ignored");
    tbl_read(0, 64'h0000_0012_3456_7003, "R10 raw read");

    disable_win(1'b0);
    lookup(48'h10000, "R9 fault after disable");
    lookup(48'h0, "R9 zero window");

    enable(0, 20, 48'h0);
    lookup(48'h0, "R7 fault during sweep");
    tbl_write(2, 64'h1111);
    settle();
    tbl_read(2, 64'h0, "R6 write during sweep ignored");
    tbl_read(1, 64'h0, "R7 table cleared on enable");
    tbl_write(15, 64'h0000_0000_CAFE_F00E);
    lookup(48'd15, "R4 shift zero clamp top");
    lookup(48'd16, "R7 clamped count");

    disable_win(1'b1);
    lookup(48'd15, "R9 disable wins");

    enable(16, 0, 48'h0);
    settle();
    lookup(48'h0, "R7 zero count stays off");

    enable(16, 4, 48'h100000);
    settle();
    tbl_write(2, 64'h0000_0123_4567_89AB);
    lookup(48'h121234, "R4/R5 shift sixteen");
    lookup(48'h140000, "R3 beyond window");
    lookup(48'h10000, "R2 under base");

    repeat (4) @(negedge clk);
    check("R1 all responses seen", 64'(q_tag.size()), 64'd0);
    finish_run();
  end
endmodule